// File: doc/BRIEF.md
# Configuration Memory Access and Security Controller

This block sits between a device programming port and the configuration storage of a logic device: the fuse map (which holds the architecture bits as ordinary words) and a signature word. It takes one command at a time over a valid/ready handshake. The commands are bulk erase, program word, read word, set security, signature write and signature read. For every accepted command it returns exactly one response, with an error flag and read data. It drives the write enable, address and write data of the external fuse array, and it gates all data that comes back from that array or from the signature store.

Two rules are enforced. First, a word can only be written once per erase. Second, once the sticky security bit is set, the block refuses every read-back and every write until a bulk erase runs. That erase is a multi-cycle sweep that zeroes the whole array. It also clears the signature, the written-word record and the security bit, all together. Refused commands change nothing and return all-zero data. The block cannot see the state of the non-volatile cells after reset, so it starts out secured and with every word treated as written.

Top module: `cfg_access_ctrl`

## Requirements
- R1: After reset, secure_o is 1, busy_o is 0, cmd_ready_o is 1 and rsp_valid_o is 0. Every word counts as already written, so a program is refused until a bulk erase has completed.
- R2: A command is accepted on a clock edge where both cmd_valid_i and cmd_ready_o are high. For every command except erase, rsp_valid_o is high for exactly one cycle, starting in the cycle after acceptance. cmd_ready_o is low while a response is pending or an erase is running.
- R3: Bulk erase (cmd_op_i = 0) holds busy_o high for exactly DEPTH cycles. During those cycles it writes zero to addresses 0 through DEPTH-1 in ascending order, one per cycle. It then gives a one-cycle response with no error in the cycle after busy_o falls to 0, and clears secure_o in that same cycle.
- R4: Program (cmd_op_i = 1) writes cmd_wdata_i to cmd_addr_i only when security is clear and the word has not been programmed since the last erase. Any other program is refused and leaves the array unchanged.
- R5: Read (cmd_op_i = 2) returns the array word at cmd_addr_i with no error while security is clear. While security is set, the read is refused.
- R6: Set security (cmd_op_i = 3) always succeeds and sets secure_o. secure_o then stays set until a bulk erase completes.
- R7: A program that succeeds with cmd_lock_i = 1 writes the word and also sets security. With any other command, cmd_lock_i has no effect.
- R8: Signature write (cmd_op_i = 4) and signature read (cmd_op_i = 5) access one DW-bit part of the SIG_W-bit signature. cmd_addr_i bit 0 selects the part: 0 for the lower half, 1 for the upper half. Both commands are refused while security is set.
- R9: A completed bulk erase clears the whole signature to zero.
- R10: Opcodes 6 and 7 are refused and change no stored state.
- R11: A refused command responds with rsp_err_o = 1 and rsp_rdata_o all zeros. Program, set security, signature write and erase return all-zero data when they succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_op_i | input | 3 | Command opcode |
| cmd_addr_i | input | AW | Word address or signature part select |
| cmd_wdata_i | input | DW | Write data |
| cmd_lock_i | input | 1 | Set security after a successful program |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_err_o | output | 1 | Command refused |
| rsp_rdata_o | output | DW | Read data, zero unless a read was granted |
| busy_o | output | 1 | Bulk erase in progress |
| secure_o | output | 1 | Security bit |
| mem_we_o | output | 1 | Fuse array write enable |
| mem_addr_o | output | AW | Fuse array address |
| mem_wdata_o | output | DW | Fuse array write data |
| mem_rdata_i | input | DW | Fuse array read data, combinational on mem_addr_o |

## Verification
The assertions check four things on every cycle: refused responses carry zero data; security never drops except when an erase finishes; the array is never written outside an erase while secured; and each response lasts a single cycle. The cycle where an erase finishes gets its own check: it must clear security and respond without error. Other behaviour depends on history, and only the bench scenarios can show it. This covers the write-once rule per erase and the exact busy length with its ascending zeroing sweep. It also covers the signature contents before and after an erase, and the refusal of every access type after a lock, whether the lock came from the set-security command or from the lock bit on a program.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;
  typedef enum logic [2:0] {
    OP_ERASE  = 3'd0,
    OP_PROG   = 3'd1,
    OP_READ   = 3'd2,
    OP_LOCK   = 3'd3,
    OP_SIG_WR = 3'd4,
    OP_SIG_RD = 3'd5
  } cfg_op_e;

  typedef struct packed {
    logic erase;
    logic prog;
    logic read;
    logic lock;
    logic sig_wr;
    logic sig_rd;
    logic refuse;
  } cfg_grant_t;
endpackage

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_access_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       secure_i,
  input  logic       dirty_i,
  output cfg_grant_t grant_o
);
  always_comb begin
    grant_o = '0;
    case (op_i)
      OP_ERASE:  grant_o.erase = 1'b1;
      OP_PROG:   if (secure_i || dirty_i) grant_o.refuse = 1'b1;
                 else grant_o.prog = 1'b1;
      OP_READ:   if (secure_i) grant_o.refuse = 1'b1;
                 else grant_o.read = 1'b1;
      OP_LOCK:   grant_o.lock = 1'b1;
      OP_SIG_WR: if (secure_i) grant_o.refuse = 1'b1;
                 else grant_o.sig_wr = 1'b1;
      OP_SIG_RD: if (secure_i) grant_o.refuse = 1'b1;
                 else grant_o.sig_rd = 1'b1;
      default:   grant_o.refuse = 1'b1;
    endcase
  end
endmodule

// File: rtl/cfg_erase_seq.sv
module cfg_erase_seq #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o
);
  logic          busy_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == AW'(DEPTH - 1)) busy_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == AW'(DEPTH - 1));
  assign addr_o = cnt_q;

  // R3
  erase_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> cnt_q == '0);
endmodule

// File: rtl/cfg_sig_store.sv
module cfg_sig_store #(
  parameter int DW    = 32,
  parameter int SIG_W = 64,
  localparam int NW = SIG_W / DW,
  localparam int SW = $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          clr_i,
  input  logic [SW-1:0] sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] word_q [NW];

  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q[g] <= '0;
      else if (clr_i) word_q[g] <= '0;
      else if (we_i && sel_i == SW'(g)) word_q[g] <= wdata_i;
    end
  end

  assign rdata_o = word_q[sel_i];
endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfg_access_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int SIG_W = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(SIG_W / DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [2:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  input  logic          cmd_lock_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          busy_o,
  output logic          secure_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  cfg_grant_t     grant;
  logic           accept;
  logic           erase_busy, erase_last;
  logic [AW-1:0]  erase_addr;
  logic [DW-1:0]  sig_rdata, rd_mux;
  logic [DEPTH-1:0] dirty_q;
  logic           secure_q;
  logic           rsp_pend_q, rsp_err_q;
  logic [DW-1:0]  rsp_data_q;

  assign cmd_ready_o = !erase_busy && !rsp_pend_q;
  assign accept      = cmd_valid_i && cmd_ready_o;

  cfg_guard i_guard (
    .op_i     (cmd_op_i),
    .secure_i (secure_q),
    .dirty_i  (dirty_q[cmd_addr_i]),
    .grant_o  (grant)
  );

  cfg_erase_seq #(.DEPTH(DEPTH)) i_erase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept && grant.erase),
    .busy_o  (erase_busy),
    .last_o  (erase_last),
    .addr_o  (erase_addr)
  );

  cfg_sig_store #(.DW(DW), .SIG_W(SIG_W)) i_sig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (accept && grant.sig_wr),
    .clr_i   (erase_last),
    .sel_i   (cmd_addr_i[SW-1:0]),
    .wdata_i (cmd_wdata_i),
    .rdata_o (sig_rdata)
  );

  // erase sweep owns the array port while busy
  assign mem_we_o    = erase_busy || (accept && grant.prog);
  assign mem_addr_o  = erase_busy ? erase_addr : cmd_addr_i;
  assign mem_wdata_o = erase_busy ? '0 : cmd_wdata_i;

  // contents unknown after reset: all words count as written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dirty_q <= '1;
    else if (erase_last) dirty_q <= '0;
    else if (accept && grant.prog) dirty_q[cmd_addr_i] <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) secure_q <= 1'b1;
    else if (erase_last) secure_q <= 1'b0;
    else if (accept && (grant.lock || (grant.prog && cmd_lock_i))) secure_q <= 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (grant.read) rd_mux = mem_rdata_i;
    else if (grant.sig_rd) rd_mux = sig_rdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_pend_q <= 1'b0;
      rsp_err_q  <= 1'b0;
      rsp_data_q <= '0;
    end else if (erase_last) begin
      rsp_pend_q <= 1'b1;
      rsp_err_q  <= 1'b0;
      rsp_data_q <= '0;
    end else if (accept && !grant.erase) begin
      rsp_pend_q <= 1'b1;
      rsp_err_q  <= grant.refuse;
      rsp_data_q <= rd_mux;
    end else begin
      rsp_pend_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_pend_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_data_q;
  assign busy_o      = erase_busy;
  assign secure_o    = secure_q;

  // R11
  refused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> rsp_rdata_o == '0);
  // R6
  secure_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    secure_o && !busy_o |=> secure_o);
  // R4
  no_prog_secure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !busy_o |-> !secure_o);
  // R2
  rsp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R3
  erase_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !secure_o && rsp_valid_o && !rsp_err_o);
endmodule

// File: tb/test_cfg_access_ctrl.sv
`timescale 1ns/1ps
module test_cfg_access_ctrl;
  localparam int DEPTH = 16;
  localparam int DW    = 32;
  localparam int SIG_W = 64;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid = 1'b0, cmd_ready, cmd_lock = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_valid, rsp_err, busy, secure;
  logic [DW-1:0] rsp_rdata;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] mem [DEPTH];
  int            n_run = 0, n_fail = 0;
  bit            done = 0;

  // reference model state
  logic [DW-1:0] exp_mem [DEPTH];
  bit            exp_dirty [DEPTH];
  bit            exp_secure = 1;
  logic [DW-1:0] exp_sig [2];
  int            erase_log [$];

  always #2.5 clk = ~clk;

  cfg_access_ctrl #(.DEPTH(DEPTH), .DW(DW), .SIG_W(SIG_W)) i_cfg_access_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .cmd_lock_i(cmd_lock),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .busy_o(busy), .secure_o(secure),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_we && busy) erase_log.push_back(int'(mem_addr));
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the security flag against the model (R6)
  always @(negedge clk) begin
    #0.5;
    if (rst_ni && !done && secure !== exp_secure) begin
      n_run++; n_fail++;
      $display("FAIL R6 per-cycle secure: actual %0b expected %0b", secure, exp_secure);
    end
  end

  task automatic do_cmd(input logic [2:0] op, input int addr, input logic [DW-1:0] wd,
                        input bit lock, input string tag);
    bit            e_err;
    logic [DW-1:0] e_data;
    int            nbusy;
    e_err = 0; e_data = '0;
    case (op)
      3'd1: e_err = exp_secure || exp_dirty[addr];
      3'd2: begin e_err = exp_secure; if (!e_err) e_data = exp_mem[addr]; end
      3'd4: e_err = exp_secure;
      3'd5: begin e_err = exp_secure; if (!e_err) e_data = exp_sig[addr % 2]; end
      3'd0, 3'd3: e_err = 0;
      default: e_err = 1;
    endcase
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = AW'(addr); cmd_wdata = wd; cmd_lock = lock;
    erase_log.delete();
    @(negedge clk);
    cmd_valid = 0; cmd_lock = 0;
    if (op == 3'd0) begin
      nbusy = 0;
      while (!rsp_valid && nbusy < 1000) begin
        if (busy) nbusy++;
        chk(!cmd_ready, {tag, " R2 ready low during erase"}, cmd_ready, 0);
        @(negedge clk);
      end
      chk(nbusy == DEPTH, {tag, " R3 busy length"}, nbusy, DEPTH);
      chk(erase_log.size() == DEPTH, {tag, " R3 erase write count"}, erase_log.size(), DEPTH);
      foreach (erase_log[i])
        if (erase_log[i] != i) chk(0, {tag, " R3 erase order"}, erase_log[i], i);
      foreach (exp_mem[i]) begin exp_mem[i] = '0; exp_dirty[i] = 0; end
      exp_sig[0] = '0; exp_sig[1] = '0;
      exp_secure = 0;
    end else begin
      if (op == 3'd1 && !e_err) begin
        exp_mem[addr] = wd; exp_dirty[addr] = 1;
        if (lock) exp_secure = 1;
      end
      if (op == 3'd3) exp_secure = 1;
      if (op == 3'd4 && !e_err) exp_sig[addr % 2] = wd;
      chk(!cmd_ready, {tag, " R2 ready low with response pending"}, cmd_ready, 0);
    end
    chk(rsp_valid === 1'b1, {tag, " R2 rsp_valid"}, rsp_valid, 1);
    chk(rsp_err === e_err, {tag, " rsp_err"}, rsp_err, e_err);
    chk(rsp_rdata === e_data, {tag, " R11 rsp_rdata"}, rsp_rdata, e_data);
    @(negedge clk);
    chk(!rsp_valid && cmd_ready, {tag, " R2 single-cycle response"}, {rsp_valid, cmd_ready}, 2'b01);
  endtask

  initial begin
    foreach (exp_mem[i]) begin exp_mem[i] = '0; exp_dirty[i] = 1; mem[i] = '0; end
    exp_sig[0] = '0; exp_sig[1] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(secure && !busy && cmd_ready && !rsp_valid, "R1 reset state",
        {secure, busy, cmd_ready, rsp_valid}, 4'b1010);

    do_cmd(3'd1, 3, 32'h1111_2222, 0, "R1 program refused before erase");
    do_cmd(3'd2, 3, '0, 0, "R5 read refused while secure");
    do_cmd(3'd5, 0, '0, 0, "R8 signature read refused while secure");

    do_cmd(3'd0, 0, '0, 0, "R3 first erase");
    do_cmd(3'd2, 3, '0, 0, "R3 word zero after erase");
    do_cmd(3'd1, 3, 32'hA5A5_5A5A, 0, "R4 program after erase");
    do_cmd(3'd2, 3, '0, 0, "R5 read programmed word");
    do_cmd(3'd1, 3, 32'hFFFF_0000, 0, "R4 second program same word");
    do_cmd(3'd2, 3, '0, 0, "R4 word unchanged after refusal");
    do_cmd(3'd1, DEPTH-1, 32'h0BAD_F00D, 0, "R4 program top address");
    do_cmd(3'd2, DEPTH-1, '0, 0, "R5 read top address");

    do_cmd(3'd4, 0, 32'hDEAD_BEEF, 0, "R8 signature write lower");
    do_cmd(3'd4, 1, 32'hCAFE_1234, 0, "R8 signature write upper");
    do_cmd(3'd5, 0, '0, 0, "R8 signature read lower");
    do_cmd(3'd5, 1, '0, 0, "R8 signature read upper");

    do_cmd(3'd6, 4, 32'h5555_5555, 0, "R10 opcode 6");
    do_cmd(3'd7, 4, 32'h6666_6666, 1, "R10 opcode 7");
    do_cmd(3'd1, 4, 32'h7777_7777, 0, "R10 word 4 still writable");
    do_cmd(3'd2, DEPTH-1, '0, 0, "R10 array unchanged");
    do_cmd(3'd5, 0, '0, 0, "R10 signature unchanged");
    do_cmd(3'd2, 4, '0, 1, "R7 lock bit ignored on read");

    do_cmd(3'd3, 0, '0, 0, "R6 set security");
    do_cmd(3'd2, 3, '0, 0, "R6 read refused after lock");
    do_cmd(3'd1, 5, 32'h1234_5678, 0, "R6 program refused after lock");
    chk(mem[5] === '0, "R6 array word 5 untouched", mem[5], 0);
    do_cmd(3'd4, 0, 32'h0000_0001, 0, "R8 signature write refused after lock");
    do_cmd(3'd5, 1, '0, 0, "R8 signature read refused after lock");
    do_cmd(3'd3, 0, '0, 0, "R6 set security again");

    do_cmd(3'd0, 0, '0, 0, "R3 erase clears security");
    do_cmd(3'd5, 0, '0, 0, "R9 signature lower cleared");
    do_cmd(3'd5, 1, '0, 0, "R9 signature upper cleared");
    do_cmd(3'd2, 3, '0, 0, "R3 word 3 cleared");

    do_cmd(3'd1, 7, 32'h0F0F_0F0F, 1, "R7 program with lock");
    chk(mem[7] === 32'h0F0F_0F0F, "R7 word written before lock", mem[7], 32'h0F0F_0F0F);
    chk(secure === 1'b1, "R7 security set by lock bit", secure, 1);
    do_cmd(3'd2, 7, '0, 0, "R7 read refused after lock bit");
    do_cmd(3'd0, 0, '0, 0, "R3 erase after lock bit");
    do_cmd(3'd2, 7, '0, 0, "R3 word 7 cleared");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule